// File: doc/BRIEF.md
# Vector Floating-Point Exception Sequencer

This block gathers the floating-point exception conditions raised by one vector instruction across all of its lanes. It handles them in two ordered phases. The operand-check phase covers invalid operand, denormal operand and divide-by-zero. The result-check phase covers overflow, underflow and inexact. Each phase has its own valid strobe. When a strobe is high, the block ORs the conditions from every lane into sticky flags in a 16-bit control/status word, and it compares them against the mask bits in that same word.

In the cycle after a phase strobe, the block answers in one of two ways for that phase:

- If any condition in the phase is unmasked, it pulses a trap request for that phase.
- If conditions are present but all of them are masked, it pulses a select that tells the datapath to write the masked default result, and execution continues.

The two phases have separate outputs. One instruction whose operand phase and result phase both hold unmasked conditions therefore requests the trap twice, once for each phase. Software loads masks and clears flags through a write port that replaces the whole word.

Top module: `simd_fpexc_seq`

## Requirements
- R1: After reset the control/status word reads 16'h1F80, with every mask bit set and every flag clear, and no trap or default-select pulse is active.
- R2: Flag bits 0..5 are invalid, denormal, divide-by-zero, overflow, underflow and inexact. Mask bits 7..12 follow the same order. Bits 6 and 13..15 always read 0, and data written to them is discarded.
- R3: On a phase strobe, each flag ORs in its condition from any lane. The flag is visible on the next cycle and stays set until a register write clears it. Masks change only on a write.
- R4: A register write loads the written masks and flags. Conditions strobed in the same cycle are ORed on top of the written flags, so they are never lost.
- R5: An operand-phase strobe with at least one unmasked invalid, denormal or divide-by-zero condition produces a one-cycle trap_pre_o pulse in the following cycle.
- R6: A result-phase strobe with at least one unmasked overflow, underflow or inexact condition produces a one-cycle trap_post_o pulse in the following cycle.
- R7: When both phases of an instruction carry unmasked conditions, two trap pulses occur, one from each phase. This also holds when the two strobes fall in the same cycle.
- R8: A phase with at least one condition, all of them masked, pulses its default-select output in the following cycle instead of a trap. The default select and the trap of one phase are never high together.
- R9: When the underflow mask is set, a lane's underflow counts only if the same lane is also inexact. When the underflow mask is clear, an underflow in any lane counts.
- R10: The trap decision and the underflow qualification use the mask bits held before a write that lands in the same cycle as the strobe.
- R11: Lane conditions have no effect on flags or outputs while their phase strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_vld_i | input | 1 | Operand-check phase strobe |
| pre_inv_i | input | LANES | Invalid operand, one bit per lane |
| pre_den_i | input | LANES | Denormal operand, one bit per lane |
| pre_dz_i | input | LANES | Divide-by-zero, one bit per lane |
| post_vld_i | input | 1 | Result-check phase strobe |
| post_ovf_i | input | LANES | Overflow, one bit per lane |
| post_unf_i | input | LANES | Tiny result, one bit per lane |
| post_inx_i | input | LANES | Inexact result, one bit per lane |
| csr_we_i | input | 1 | Control/status write enable |
| csr_wdata_i | input | 16 | Control/status write data |
| csr_o | output | 16 | Control/status word |
| trap_pre_o | output | 1 | Trap request from the operand phase |
| trap_post_o | output | 1 | Trap request from the result phase |
| dflt_pre_o | output | 1 | Masked default select, operand phase |
| dflt_post_o | output | 1 | Masked default select, result phase |

## Verification
Two activities can land on the same clock edge: a software write to the control/status word and a phase strobe. The bench issues writes together with strobes, once with the write unmasking a condition and once with it masking one, and once with it clearing flags that the strobe is setting again. It then judges whether the pulses follow the old masks and whether the flags hold the written value ORed with the new conditions. The two phase strobes are also raised in the same cycle, to confirm that both trap pulses appear together.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NCOND    = 6;
  localparam int NPHASE   = 3;
  localparam int CSR_W    = 16;
  localparam int MASK_LSB = 7;
  localparam int UNF_MASK_BIT = MASK_LSB + 4;
  localparam logic [CSR_W-1:0] CSR_RST   = 16'h1F80;
  localparam logic [CSR_W-1:0] CSR_WMASK = 16'h1FBF;

  typedef struct packed {
    logic inx;
    logic unf;
    logic ovf;
    logic dz;
    logic den;
    logic inv;
  } cond_t;
endpackage

// File: rtl/fpx_lane_reduce.sv
module fpx_lane_reduce #(
  parameter int LANES    = 4,
  parameter bit UNF_QUAL = 1'b0
) (
  input  logic [LANES-1:0] c0_i,
  input  logic [LANES-1:0] c1_i,
  input  logic [LANES-1:0] c2_i,
  input  logic             unf_masked_i,
  output logic [2:0]       any_o
);
  logic [LANES-1:0] c1_q;

  generate
    if (UNF_QUAL) begin : g_qual
      // masked underflow counts only when the same lane is inexact
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign c1_q[l] = c1_i[l] & (c2_i[l] | ~unf_masked_i);
      end
    end else begin : g_plain
      assign c1_q = c1_i;
    end
  endgenerate

  assign any_o = {|c2_i, |c1_q, |c0_i};

  logic unused_ok;
  assign unused_ok = unf_masked_i & 1'b0;
endmodule

// File: rtl/fpx_phase_eval.sv
module fpx_phase_eval #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] mask_i,
  output logic         trap_o,
  output logic         dflt_o
);
  logic hit, unm;

  assign hit = vld_i & (|cond_i);
  assign unm = vld_i & (|(cond_i & ~mask_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o <= 1'b0;
      dflt_o <= 1'b0;
    end else begin
      trap_o <= unm;
      dflt_o <= hit & ~unm;
    end
  end
endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
  import fpx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  input  logic [NCOND-1:0] set_i,
  output logic [CSR_W-1:0] q_o
);
  logic [CSR_W-1:0] base, nxt;

  always_comb begin
    base = we_i ? (wdata_i & CSR_WMASK) : q_o;
    nxt  = base;
    nxt[NCOND-1:0] = base[NCOND-1:0] | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= CSR_RST;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/simd_fpexc_seq.sv
module simd_fpexc_seq
  import fpx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_vld_i,
  input  logic [LANES-1:0] pre_inv_i,
  input  logic [LANES-1:0] pre_den_i,
  input  logic [LANES-1:0] pre_dz_i,
  input  logic             post_vld_i,
  input  logic [LANES-1:0] post_ovf_i,
  input  logic [LANES-1:0] post_unf_i,
  input  logic [LANES-1:0] post_inx_i,
  input  logic             csr_we_i,
  input  logic [15:0]      csr_wdata_i,
  output logic [15:0]      csr_o,
  output logic             trap_pre_o,
  output logic             trap_post_o,
  output logic             dflt_pre_o,
  output logic             dflt_post_o
);
  logic [CSR_W-1:0]  csr_q;
  logic [NPHASE-1:0] pre_any, post_any;
  logic [NCOND-1:0]  mask_q;
  cond_t             set_c;

  assign mask_q = csr_q[MASK_LSB +: NCOND];

  fpx_lane_reduce #(.LANES(LANES), .UNF_QUAL(1'b0)) u_pre_red (
    .c0_i(pre_inv_i), .c1_i(pre_den_i), .c2_i(pre_dz_i),
    .unf_masked_i(1'b0), .any_o(pre_any)
  );

  fpx_lane_reduce #(.LANES(LANES), .UNF_QUAL(1'b1)) u_post_red (
    .c0_i(post_ovf_i), .c1_i(post_unf_i), .c2_i(post_inx_i),
    .unf_masked_i(csr_q[UNF_MASK_BIT]), .any_o(post_any)
  );

  assign set_c = cond_t'({post_any & {NPHASE{post_vld_i}},
                          pre_any  & {NPHASE{pre_vld_i}}});

  fpx_phase_eval #(.W(NPHASE)) u_pre_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(pre_vld_i),
    .cond_i(pre_any), .mask_i(mask_q[NPHASE-1:0]),
    .trap_o(trap_pre_o), .dflt_o(dflt_pre_o)
  );

  fpx_phase_eval #(.W(NPHASE)) u_post_eval (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(post_vld_i),
    .cond_i(post_any), .mask_i(mask_q[NCOND-1:NPHASE]),
    .trap_o(trap_post_o), .dflt_o(dflt_post_o)
  );

  fpx_csr u_csr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(csr_we_i),
    .wdata_i(csr_wdata_i), .set_i(set_c), .q_o(csr_q)
  );

  assign csr_o = csr_q;
endmodule

// File: rtl/fpx_chk.sv
module fpx_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pre_vld_i,
  input logic [LANES-1:0] pre_inv_i,
  input logic [LANES-1:0] pre_den_i,
  input logic [LANES-1:0] pre_dz_i,
  input logic             post_vld_i,
  input logic [LANES-1:0] post_ovf_i,
  input logic [LANES-1:0] post_unf_i,
  input logic [LANES-1:0] post_inx_i,
  input logic             csr_we_i,
  input logic [15:0]      csr_wdata_i,
  input logic [15:0]      csr_o,
  input logic             trap_pre_o,
  input logic             trap_post_o,
  input logic             dflt_pre_o,
  input logic             dflt_post_o
);
  logic pre_unm, post_unm_ovf;
  assign pre_unm = (|pre_inv_i & ~csr_o[7]) | (|pre_den_i & ~csr_o[8]) | (|pre_dz_i & ~csr_o[9]);
  assign post_unm_ovf = |post_ovf_i & ~csr_o[10];

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[6] == 1'b0 && csr_o[15:13] == 3'b000); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> ((csr_o[5:0] & $past(csr_o[5:0])) == $past(csr_o[5:0]))); // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> $stable(csr_o[12:7])); // R3
  AST_PRE_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_vld_i && pre_unm |=> trap_pre_o); // R5
  AST_POST_OVF_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_vld_i && post_unm_ovf |=> trap_post_o); // R6
  AST_TRAP_PRE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_pre_o |-> $past(pre_vld_i)); // R5
  AST_TRAP_POST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_post_o |-> $past(post_vld_i)); // R6
  AST_DFLT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_pre_o && dflt_pre_o) && !(trap_post_o && dflt_post_o)); // R8
  AST_UNF_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_vld_i && !csr_we_i && csr_o[11] && !csr_o[4] && ((post_unf_i & post_inx_i) == '0)
    |=> !csr_o[4]); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_vld_i && !post_vld_i |=> !trap_pre_o && !trap_post_o && !dflt_pre_o && !dflt_post_o); // R11
endmodule

bind simd_fpexc_seq fpx_chk #(.LANES(LANES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .pre_vld_i(pre_vld_i), .pre_inv_i(pre_inv_i), .pre_den_i(pre_den_i), .pre_dz_i(pre_dz_i),
  .post_vld_i(post_vld_i), .post_ovf_i(post_ovf_i), .post_unf_i(post_unf_i), .post_inx_i(post_inx_i),
  .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i), .csr_o(csr_o),
  .trap_pre_o(trap_pre_o), .trap_post_o(trap_post_o),
  .dflt_pre_o(dflt_pre_o), .dflt_post_o(dflt_post_o)
);

// File: tb/sim_simd_fpexc_seq.sv
`timescale 1ns/1ps
module sim_simd_fpexc_seq;
  localparam int LANES = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pv = 0, qv = 0, we = 0;
  logic [LANES-1:0] inv = 0, den = 0, dz = 0, ovf = 0, unf = 0, inx = 0;
  logic [15:0] wd = 0;
  logic [15:0] csr;
  logic tp, tq, dp, dq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] m_csr;
  logic m_tp, m_tq, m_dp, m_dq;

  always #2.5 clk = ~clk;

  simd_fpexc_seq #(.LANES(LANES)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .pre_vld_i(pv), .pre_inv_i(inv), .pre_den_i(den), .pre_dz_i(dz),
    .post_vld_i(qv), .post_ovf_i(ovf), .post_unf_i(unf), .post_inx_i(inx),
    .csr_we_i(we), .csr_wdata_i(wd), .csr_o(csr),
    .trap_pre_o(tp), .trap_post_o(tq), .dflt_pre_o(dp), .dflt_post_o(dq)
  );

  task automatic compare(string tag);
    checks++;
    if (csr !== m_csr || tp !== m_tp || tq !== m_tq || dp !== m_dp || dq !== m_dq) begin
      failures++;
      $display("FAIL %s: act csr=%h tp=%b tq=%b dp=%b dq=%b exp csr=%h tp=%b tq=%b dp=%b dq=%b",
               tag, csr, tp, tq, dp, dq, m_csr, m_tp, m_tq, m_dp, m_dq);
    end
  endtask

  // behavioural next-state of the reference from the current inputs
  task automatic model_step();
    bit a_inv = 0, a_den = 0, a_dz = 0, a_ovf = 0, a_unf = 0, a_inx = 0;
    bit u_pre, u_post;
    logic [15:0] n;
    for (int l = 0; l < LANES; l++) begin
      if (inv[l]) a_inv = 1;
      if (den[l]) a_den = 1;
      if (dz[l])  a_dz  = 1;
      if (ovf[l]) a_ovf = 1;
      if (inx[l]) a_inx = 1;
      if (unf[l] && (inx[l] || !m_csr[11])) a_unf = 1;
    end
    u_pre  = (a_inv && !m_csr[7]) || (a_den && !m_csr[8]) || (a_dz && !m_csr[9]);
    u_post = (a_ovf && !m_csr[10]) || (a_unf && !m_csr[11]) || (a_inx && !m_csr[12]);
    n = we ? (wd & 16'h1FBF) : m_csr;
    if (pv) n = n | {13'd0, a_dz, a_den, a_inv};
    if (qv) n = n | {10'd0, a_inx, a_unf, a_ovf, 3'd0};
    m_tp = pv && u_pre;
    m_dp = pv && (a_inv || a_den || a_dz) && !u_pre;
    m_tq = qv && u_post;
    m_dq = qv && (a_ovf || a_unf || a_inx) && !u_post;
    m_csr = n;
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    pv = 0; qv = 0; we = 0;
    inv = 0; den = 0; dz = 0; ovf = 0; unf = 0; inx = 0; wd = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: act hung exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_csr = 16'h1F80; m_tp = 0; m_tq = 0; m_dp = 0; m_dq = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after reset");

    // R11: conditions without strobe
    inv = 4'hF; ovf = 4'hF; unf = 4'hF; inx = 4'hF; cyc("R11 no strobe");
    cyc("R11 idle");

    // R2: reserved bits dropped
    we = 1; wd = 16'hFFFF; cyc("R2 write all ones");
    we = 1; wd = 16'h1F80; cyc("R2 clear flags");

    // R8: all masked -> default select
    pv = 1; den = 4'b0100; cyc("R8 pre masked");
    cyc("R8 pulse ends");
    qv = 1; ovf = 4'b0001; inx = 4'b1000; cyc("R8 post masked");
    cyc("R3 flags sticky");

    // R9: masked underflow needs same-lane inexact
    we = 1; wd = 16'h1F80; cyc("R4 clear");
    qv = 1; unf = 4'b0010; inx = 4'b0100; cyc("R9 unf masked, other lane inexact");
    qv = 1; unf = 4'b0100; inx = 4'b0100; cyc("R9 unf masked, same lane inexact");

    // unmask all
    we = 1; wd = 16'h0000; cyc("R4 unmask all");
    qv = 1; unf = 4'b0001; cyc("R9 unmasked tiny alone");
    pv = 1; dz = 4'b1000; cyc("R5 pre trap");
    cyc("R5 one cycle");
    qv = 1; ovf = 4'b0010; cyc("R6 post trap");

    // R7: two traps, sequential and coincident
    pv = 1; inv = 4'b0001; cyc("R7 first phase");
    qv = 1; inx = 4'b0001; cyc("R7 second phase");
    pv = 1; den = 4'b0010; qv = 1; ovf = 4'b0100; cyc("R7 same cycle");

    // R10/R4: write concurrent with strobe uses old masks
    we = 1; wd = 16'h1F80; pv = 1; inv = 4'b0001; cyc("R10 mask write with strobe");
    we = 1; wd = 16'h0000; pv = 1; den = 4'b0001; cyc("R10 unmask write with strobe");
    we = 1; wd = 16'h0000; qv = 1; ovf = 4'b1111; cyc("R4 clear vs set");
    we = 1; wd = 16'h0800; qv = 1; unf = 4'b0001; cyc("R10 unf qual uses old mask");

    // mixed masks, random traffic
    for (int i = 0; i < 400; i++) begin
      pv = $urandom_range(0, 1); qv = $urandom_range(0, 1);
      inv = $urandom_range(0, 15) & {4{$urandom_range(0, 3) == 0}};
      den = $urandom_range(0, 15) & {4{$urandom_range(0, 3) == 0}};
      dz  = $urandom_range(0, 15) & {4{$urandom_range(0, 3) == 0}};
      ovf = $urandom_range(0, 15) & {4{$urandom_range(0, 3) == 0}};
      unf = $urandom_range(0, 15);
      inx = $urandom_range(0, 15);
      we = ($urandom_range(0, 7) == 0);
      wd = 16'($urandom);
      cyc("R3 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule